// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block is a small cache that sits between a CPU and a slow main memory addressed by word. It holds eight lines of four words each, 32 words in all. Each request word address selects exactly one line slot. A request that finds its line present with a matching tag completes in the same cycle. A request that misses first hands a modified victim line to a write buffer, if there is one. It then loads the whole aligned four-word line that contains the requested word and answers after that.

Writes are write-back with write-allocate. A write hit changes only the cached word and marks the line dirty. A write miss loads the line and then merges the word. Clean victims are dropped without any memory traffic. Dirty victims leave as one whole-line transfer on the write-buffer port, so main memory is never written one word at a time.

The CPU holds a request (valid, write enable, address, write data) stable until `ready_o` is high for one cycle. In that cycle `hit_o` tells whether the line was already present, and on reads `rdata_o` carries the word.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid and clean, so the first access to any address misses, and `ready_o`, `fill_req_o` and `wb_valid_o` are low while no request is pending.
- R2: A request hits only when the indexed line is valid and its stored tag equals the request tag. A hit raises `ready_o` and `hit_o` in the same cycle as the request and returns the stored word on `rdata_o`.
- R3: The word address is split as follows: bits [1:0] select the word in the line, bits [4:2] select the line slot, and the remaining high bits form the tag. Two addresses with the same slot and different tags displace each other.
- R4: On a miss the cache drives `fill_addr_o` with the request address and its low two bits cleared. It takes the four words of that line in ascending order, one on each cycle in which `fill_valid_i` is high. The memory may insert idle cycles between words.
- R5: A miss is answered with `ready_o` high and `hit_o` low in the cycle after the fourth fill word is accepted. A read returns the requested word from the newly loaded line.
- R6: The read trace 1, 7, 6, 5, 32, 33, 1, 2 from reset gives miss, miss, hit, hit, miss, hit, miss, hit.
- R7: A write hit updates the addressed word and marks the line dirty. It causes no fill and no write-buffer transfer.
- R8: A write miss loads the line, then writes the word and marks the line dirty. It is answered with `hit_o` low.
- R9: When a miss displaces a dirty line, the whole victim line is presented on `wb_data_o` (word k in bits [32k+31:32k]), with its base word address on `wb_addr_o`. This happens before the fill starts, and the transfer is done on a cycle where both `wb_valid_o` and `wb_ready_i` are high.
- R10: Displacing a clean line produces no write-buffer transfer.
- R11: While `wb_valid_o` is high and `wb_ready_i` is low, the victim address and data stay unchanged, no fill is requested, and the CPU request is not answered.
- R12: `ready_o` is high only while `req_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request pending |
| req_we_i | input | 1 | Request is a write |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Request completes this cycle |
| hit_o | output | 1 | Completing request found its line present |
| rdata_o | output | DATA_W | Read data |
| fill_req_o | output | 1 | Line fill in progress |
| fill_addr_o | output | ADDR_W | Base word address of the line being filled |
| fill_valid_i | input | 1 | Fill word present |
| fill_data_i | input | DATA_W | Fill word |
| wb_valid_o | output | 1 | Dirty victim line offered |
| wb_ready_i | input | 1 | Write buffer accepts the line |
| wb_addr_o | output | ADDR_W | Base word address of the victim line |
| wb_data_o | output | WORDS*DATA_W | Victim line data |

## Verification
A bad valid bit or tag shows at the ports at once: `hit_o` is wrong in the same cycle the request arrives, and a fill either happens when it should not or is missing. A wrong fill beat counter or a bad word placement stays hidden until a later hit reads the affected word. A lost or stray dirty bit shows only when that line is evicted, either as a missing `wb_valid_o` or as stale data after a later refill. For this reason the tests write, evict and re-read the same words.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             fill_done_i,
  input  logic             dirty_set_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             valid_o,
  output logic             dirty_o
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_done_i) begin
        valid_q[idx_i] <= 1'b1;
        dirty_q[idx_i] <= 1'b0;
      end
      if (dirty_set_i) dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_done_i) tag_q[idx_i] <= tag_i;
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];

  // R4
  fill_marks_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_i |=> (valid_o && !dirty_o));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic                    wr_en_i,
  input  logic [OFF_W-1:0]        wr_off_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [OFF_W-1:0]        rd_off_i,
  output logic [DATA_W-1:0]       rd_word_o,
  output logic [WORDS*DATA_W-1:0] line_o
);
  logic [DATA_W-1:0] mem_q [LINES][WORDS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[idx_i][wr_off_i] <= wr_data_i;
  end

  assign rd_word_o = mem_q[idx_i][rd_off_i];

  for (genvar w = 0; w < WORDS; w++) begin : g_line
    assign line_o[w*DATA_W +: DATA_W] = mem_q[idx_i][w];
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl import dmc_pkg::*; #(
  parameter int WORDS = 4,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             hit_i,
  input  logic             victim_valid_i,
  input  logic             victim_dirty_i,
  input  logic             wb_ready_i,
  input  logic             fill_valid_i,
  output logic             ready_o,
  output logic             hit_o,
  output logic             wb_valid_o,
  output logic             fill_req_o,
  output logic             fill_done_o,
  output logic             dirty_set_o,
  output logic             dwr_en_o,
  output logic             dwr_fill_o,
  output logic [OFF_W-1:0] beat_o
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  dmc_state_e state_q, state_d;
  logic [OFF_W-1:0] beat_q, beat_d;

  always_comb begin
    state_d     = state_q;
    beat_d      = beat_q;
    ready_o     = 1'b0;
    hit_o       = 1'b0;
    wb_valid_o  = 1'b0;
    fill_req_o  = 1'b0;
    fill_done_o = 1'b0;
    dirty_set_o = 1'b0;
    dwr_en_o    = 1'b0;
    dwr_fill_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        beat_d = '0;
        if (req_valid_i) begin
          if (hit_i) begin
            ready_o     = 1'b1;
            hit_o       = 1'b1;
            dwr_en_o    = req_we_i;
            dirty_set_o = req_we_i;
          end else if (victim_valid_i && victim_dirty_i) begin
            state_d = ST_EVICT;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        wb_valid_o = 1'b1;
        if (wb_ready_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        fill_req_o = 1'b1;
        if (fill_valid_i) begin
          dwr_en_o   = 1'b1;
          dwr_fill_o = 1'b1;
          beat_d     = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            fill_done_o = 1'b1;
            state_d     = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        ready_o     = 1'b1;
        dwr_en_o    = req_we_i;
        dirty_set_o = req_we_i;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign beat_o = beat_q;

  // R12
  ready_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> req_valid_i);
endmodule

// File: rtl/dm_cache.sv
module dm_cache import dmc_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  output logic                    ready_o,
  output logic                    hit_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    fill_req_o,
  output logic [ADDR_W-1:0]       fill_addr_o,
  input  logic                    fill_valid_i,
  input  logic [DATA_W-1:0]       fill_data_i,
  output logic                    wb_valid_o,
  input  logic                    wb_ready_i,
  output logic [ADDR_W-1:0]       wb_addr_o,
  output logic [WORDS*DATA_W-1:0] wb_data_o
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign {req_tag, req_idx, req_off} = req_addr_i;

  logic [TAG_W-1:0] line_tag;
  logic line_valid, line_dirty, lookup_hit;
  logic fill_done, dirty_set, dwr_en, dwr_fill;
  logic [OFF_W-1:0] beat;
  logic [OFF_W-1:0] wr_off;
  logic [DATA_W-1:0] wr_data;

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (req_idx),
    .tag_i       (req_tag),
    .fill_done_i (fill_done),
    .dirty_set_i (dirty_set),
    .tag_o       (line_tag),
    .valid_o     (line_valid),
    .dirty_o     (line_dirty)
  );

  assign lookup_hit = line_valid && (line_tag == req_tag);

  dmc_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_we_i       (req_we_i),
    .hit_i          (lookup_hit),
    .victim_valid_i (line_valid),
    .victim_dirty_i (line_dirty),
    .wb_ready_i     (wb_ready_i),
    .fill_valid_i   (fill_valid_i),
    .ready_o        (ready_o),
    .hit_o          (hit_o),
    .wb_valid_o     (wb_valid_o),
    .fill_req_o     (fill_req_o),
    .fill_done_o    (fill_done),
    .dirty_set_o    (dirty_set),
    .dwr_en_o       (dwr_en),
    .dwr_fill_o     (dwr_fill),
    .beat_o         (beat)
  );

  assign wr_off  = dwr_fill ? beat : req_off;
  assign wr_data = dwr_fill ? fill_data_i : req_wdata_i;

  dmc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .idx_i     (req_idx),
    .wr_en_i   (dwr_en),
    .wr_off_i  (wr_off),
    .wr_data_i (wr_data),
    .rd_off_i  (req_off),
    .rd_word_o (rdata_o),
    .line_o    (wb_data_o)
  );

  assign fill_addr_o = {req_tag, req_idx, {OFF_W{1'b0}}};
  assign wb_addr_o   = {line_tag, req_idx, {OFF_W{1'b0}}};

  // R11
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o)));

  // R9
  wb_only_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (line_valid && line_dirty));

  // R5
  miss_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !hit_o) |-> ($past(fill_req_o) && $past(fill_valid_i)));

  // R4
  fill_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |-> (fill_addr_o[ADDR_W-1:OFF_W] == req_addr_i[ADDR_W-1:OFF_W]));
endmodule

// File: tb/sim_dm_cache.sv
`timescale 1ns/1ps
module sim_dm_cache;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic ready_o, hit_o, fill_req_o, wb_valid_o;
  logic [DW-1:0] rdata_o;
  logic [AW-1:0] fill_addr_o, wb_addr_o;
  logic fill_valid_i = 1'b0;
  logic [DW-1:0] fill_data_i = '0;
  logic wb_ready_i = 1'b1;
  logic [4*DW-1:0] wb_data_o;

  always #4 clk = ~clk;

  dm_cache u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .ready_o(ready_o), .hit_o(hit_o), .rdata_o(rdata_o),
    .fill_req_o(fill_req_o), .fill_addr_o(fill_addr_o), .fill_valid_i(fill_valid_i),
    .fill_data_i(fill_data_i), .wb_valid_o(wb_valid_o), .wb_ready_i(wb_ready_i),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] mem [1024];
  logic [DW-1:0] ref_mem [1024];
  int beat_m = 0, fill_cnt = 0, wb_cnt = 0;
  bit slow = 0, tick = 0;
  logic [AW-1:0] last_fill_addr = '0, last_wb_addr = '0;
  logic [4*DW-1:0] last_wb_data = '0;

  localparam logic [AW-1:0] TR_ADDR [8] = '{16'd1, 16'd7, 16'd6, 16'd5, 16'd32, 16'd33, 16'd1, 16'd2};
  localparam bit TR_HIT [8] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  // slow main memory: line fill source
  always @(negedge clk) begin
    if (fill_req_o) begin
      tick = ~tick;
      if (!slow || tick) begin
        if (beat_m == 0) begin
          last_fill_addr = fill_addr_o;
          fill_cnt++;
        end
        fill_valid_i = 1'b1;
        fill_data_i  = mem[(fill_addr_o + AW'(beat_m)) % 1024];
        beat_m++;
      end else begin
        fill_valid_i = 1'b0;
      end
    end else begin
      fill_valid_i = 1'b0;
      beat_m = 0;
      tick = 0;
    end
  end

  // write buffer sink
  always @(negedge clk) begin
    #2;
    if (wb_valid_o && wb_ready_i) begin
      wb_cnt++;
      last_wb_addr = wb_addr_o;
      last_wb_data = wb_data_o;
      for (int k = 0; k < 4; k++) mem[(wb_addr_o + AW'(k)) % 1024] = wb_data_o[k*DW +: DW];
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid_i = 1'b1;
    req_we_i    = we;
    req_addr_i  = a;
    req_wdata_i = d;
    if (we) ref_mem[a % 1024] = d;
  endtask

  task automatic wait_resp(output bit h, output logic [DW-1:0] rd);
    bit got = 0;
    while (!got) begin
      #1;
      if (ready_o) begin
        got = 1;
        h = hit_o;
        rd = rdata_o;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    req_we_i = 1'b0;
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output bit h, output logic [DW-1:0] rd);
    start_req(we, a, d);
    wait_resp(h, rd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit h;
    logic [DW-1:0] rd;
    int f0, w0;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'hA000_0000 + DW'(i);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    check("R1 ready idle", ready_o, 0);
    check("R1 fill idle", fill_req_o, 0);
    check("R1 wb idle", wb_valid_o, 0);
    @(negedge clk);

    // R6 trace; also R2 hit data and R5 miss data
    for (int i = 0; i < 8; i++) begin
      access(0, TR_ADDR[i], '0, h, rd);
      check($sformatf("R6 hit idx%0d", i), h, TR_HIT[i]);
      check($sformatf("R2 R5 rdata idx%0d", i), rd, ref_mem[TR_ADDR[i]]);
      if (i == 4) check("R4 fill base", last_fill_addr, 16'd32);
    end
    check("R10 clean eviction no wb", wb_cnt, 0);
    #1;
    check("R12 ready low without req", ready_o, 0);
    @(negedge clk);

    // R7 write hit
    f0 = fill_cnt; w0 = wb_cnt;
    access(1, 16'd2, 32'hDEAD_0002, h, rd);
    check("R7 write hit", h, 1);
    check("R7 no fill", fill_cnt, f0);
    check("R7 no wb", wb_cnt, w0);
    access(0, 16'd2, '0, h, rd);
    check("R7 readback", rd, 32'hDEAD_0002);

    // R11 / R9 dirty eviction under backpressure
    wb_ready_i = 1'b0;
    start_req(0, 16'd34, '0);
    repeat (3) @(negedge clk);
    #1;
    check("R11 wb held", wb_valid_o, 1);
    check("R11 no fill while held", fill_req_o, 0);
    check("R11 no answer while held", ready_o, 0);
    check("R9 wb addr", wb_addr_o, 16'd0);
    wb_ready_i = 1'b1;
    wait_resp(h, rd);
    check("R9 wb count", wb_cnt, 1);
    check("R9 wb word2", last_wb_data[2*DW +: DW], 32'hDEAD_0002);
    check("R9 wb word0", last_wb_data[0 +: DW], 32'hA000_0000);
    check("R5 miss flag", h, 0);
    check("R5 miss data", rd, 32'hA000_0022);

    // R8 write miss with slow fill
    slow = 1;
    access(1, 16'd9, 32'hBEEF_0009, h, rd);
    check("R8 write miss flag", h, 0);
    check("R8 no wb on empty slot", wb_cnt, 1);
    check("R4 fill base slow", last_fill_addr, 16'd8);
    access(0, 16'd9, '0, h, rd);
    check("R8 readback hit", h, 1);
    check("R8 readback data", rd, 32'hBEEF_0009);
    access(0, 16'd10, '0, h, rd);
    check("R4 ascending order word2", rd, 32'hA000_000A);
    access(0, 16'd41, '0, h, rd);
    check("R8 dirty evicted", wb_cnt, 2);
    check("R9 wb addr line8", last_wb_addr, 16'd8);
    check("R9 wb word1", last_wb_data[DW +: DW], 32'hBEEF_0009);
    check("R5 data 41", rd, 32'hA000_0029);
    slow = 0;

    // R3 index/tag split
    access(0, 16'd4, '0, h, rd);
    check("R3 same tag hit", h, 1);
    access(0, 16'd36, '0, h, rd);
    check("R3 same slot other tag miss", h, 0);
    access(0, 16'd4, '0, h, rd);
    check("R3 displaced back miss", h, 0);
    access(0, 16'd9, '0, h, rd);
    check("R9 written-back data returned", rd, 32'hBEEF_0009);
    access(0, 16'h0104, '0, h, rd);
    check("R3 high tag bit miss", h, 0);
    check("R3 high tag data", rd, mem[16'h0104]);

    // R1 reset again
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    access(0, 16'd9, '0, h, rd);
    check("R1 miss after reset", h, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule